// File: doc/BRIEF.md
# Interval Timer with Watchdog Mode

This block is one timer channel behind a small word-addressed register bus. The bus clock first passes through a 16-bit prescaler. The prescaled ticks then drive a 16-bit period counter. When the period counter expires, the block sets an event flag in the status word. In single-shot operation the timer then stops. In continuous operation it reloads and keeps running. The flag drives the timer-event output while the interrupt-enable bit is set.

One mode bit turns the channel into a watchdog. In this mode the interrupt enable is forced off. Software must write the keep-alive byte 0xA5 into the top byte of the mode word before the interval runs out. If it does not, the block pulses a reset request for one cycle and stops. While the watchdog runs, it is protected: the only mode write it accepts is one that clears both the run bit and the watchdog bit.

The bus has three words, selected by `bus_addr`: 0 is mode, 1 is count, 2 is status, and 3 reads as zero. Writes take effect on the clock edge where `bus_wr` is high. `bus_wstrb[b]` enables byte b, which is bits 8b+7:8b. Read data is combinational from `bus_addr`.

Top module: `interval_wdt_timer`

## Requirements
- R1: After reset the mode, count and status words all read 0, and both `tmr_event` and `wdt_reset` are low.
- R2: The count word holds the prescaler P in bits 31:16 and the period L in bits 15:0. After the write edge that sets the run bit (mode bit 12) from 0 to 1, status bit 0 becomes 1 at exactly the P*L-th following rising edge.
- R3: A prescaler field of 0 divides by 65536. A period field of 0 counts 65536 prescaled ticks.
- R4: Clearing mode bit 12 freezes counting, so no expiry occurs. Setting it again restarts a full interval.
- R5: With mode bit 10 clear, the timer expires once and mode bit 12 then reads 0.
- R6: With mode bit 10 set, the timer reloads and expires again every P*L cycles, and mode bit 12 stays 1.
- R7: Status bits 3:0 are event flags. Writing 1 to a flag clears it, and writing 0 leaves it unchanged. `tmr_event` is high exactly when some flag is set and mode bit 8 (interrupt enable) is 1.
- R8: Any mode write that sets bit 15 (watchdog) stores bit 8 as 0, so a watchdog expiry leaves `tmr_event` low.
- R9: While the watchdog runs (bits 15 and 12 both set), a write of byte 0xA5 to bits 31:24 with strobe 3 restarts the full interval. Any other byte value has no effect.
- R10: A watchdog expiry raises `wdt_reset` for exactly one cycle and clears mode bit 12.
- R11: While the watchdog runs, a mode write that leaves bit 15 or bit 12 set is ignored. A write that clears both bits stops the watchdog, and no reset request follows.
- R12: A count write while running is stored at once but first used at the next reload. The current interval keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, the counting source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 2 | Word select: 0 mode, 1 count, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Read data of the addressed word |
| tmr_event | output | 1 | Event request: set flags gated by interrupt enable |
| wdt_reset | output | 1 | One-cycle watchdog reset request |

## Verification
Most faults in the counter chain show up at the ports as an expiry that arrives one or more cycles early or late. So every interval check samples the status flag on the edge just before the predicted expiry and on the edge of it, which exposes an off-by-one within a single interval.

A wrong reload or a wrong choice between the shadow and active count only appears one interval later. For that reason the continuous test spans two periods of different length.

Faults in the watchdog lock or the keep-alive key show up as a reset pulse on the wrong edge, or as a mode word that reads back changed, straight after the offending write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 16;
    localparam int PER_W  = 16;
    localparam int CNT_W  = PRE_W + PER_W;
    localparam int FLAG_W = 4;
    localparam int NBYTES = DATA_W / 8;

    localparam logic [7:0] KICK_KEY = 8'hA5;

    localparam int BIT_IRQ  = 8;
    localparam int BIT_CONT = 10;
    localparam int BIT_RUN  = 12;
    localparam int BIT_WDT  = 15;

    typedef enum logic [1:0] {
        REG_MODE  = 2'd0,
        REG_COUNT = 2'd1,
        REG_STAT  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wdt;
        logic run;
        logic cont;
        logic irq;
    } mode_t;
endpackage

// File: rtl/tmr_stage.sv
module tmr_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         wrap_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic at_end;

    always_comb begin
        st_d   = st_q;
        // limit 0 wraps to all ones: a full 2^W count
        at_end = (st_q.cnt == (limit - ONE));
        wrap_o = run && !restart && at_end;
        if (restart) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = at_end ? '0 : (st_q.cnt + ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (st_q.cnt == '0)) else $error("stage wrap"); // R2
    AST_STAGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0)) else $error("stage restart"); // R4
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NBYTES-1:0] bus_wstrb,
    input  logic              expire,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              restart,
    output logic              run,
    output logic [PRE_W-1:0]  act_pre,
    output logic [PER_W-1:0]  act_per,
    output logic              event_o,
    output logic              wdt_rst_o
);
    typedef struct packed {
        mode_t             mode;
        logic [CNT_W-1:0]  count;
        logic [PRE_W-1:0]  act_pre;
        logic [PER_W-1:0]  act_per;
        logic [FLAG_W-1:0] flags;
        logic              wdt_rst;
    } st_t;

    st_t              st_d, st_q;
    reg_sel_e         sel;
    logic             locked, wr_mode, mode_byte, kick;
    mode_t            nm;
    logic [CNT_W-1:0] cnt_new;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        sel     = reg_sel_e'(bus_addr);
        locked  = st_q.mode.wdt && st_q.mode.run;
        wr_mode = bus_wr && (sel == REG_MODE);

        // byte-merged count word
        cnt_new = st_q.count;
        for (int b = 0; b < NBYTES; b++) begin
            if (bus_wstrb[b]) cnt_new[8*b +: 8] = bus_wdata[8*b +: 8];
        end
        if (bus_wr && sel == REG_COUNT) begin
            st_d.count = cnt_new;
            if (!st_q.mode.run) begin
                st_d.act_pre = cnt_new[CNT_W-1:PER_W];
                st_d.act_per = cnt_new[PER_W-1:0];
            end
        end

        // mode word: control bits live in byte 1
        mode_byte = wr_mode && bus_wstrb[1];
        nm.wdt    = bus_wdata[BIT_WDT];
        nm.run    = bus_wdata[BIT_RUN];
        nm.cont   = bus_wdata[BIT_CONT];
        nm.irq    = bus_wdata[BIT_IRQ] && !bus_wdata[BIT_WDT];
        if (mode_byte && (!locked || (!nm.wdt && !nm.run))) begin
            st_d.mode = nm;
            if (nm.run && !st_q.mode.run) begin
                restart      = 1'b1;
                st_d.act_pre = st_d.count[CNT_W-1:PER_W];
                st_d.act_per = st_d.count[PER_W-1:0];
            end
        end

        // keep-alive key in the top byte
        kick = wr_mode && bus_wstrb[NBYTES-1] && locked &&
               (bus_wdata[DATA_W-1 -: 8] == KICK_KEY);
        if (kick) begin
            restart      = 1'b1;
            st_d.act_pre = st_d.count[CNT_W-1:PER_W];
            st_d.act_per = st_d.count[PER_W-1:0];
        end

        // status: write one to clear
        if (bus_wr && sel == REG_STAT && bus_wstrb[0]) begin
            st_d.flags = st_q.flags & ~bus_wdata[FLAG_W-1:0];
        end

        // expiry handling wins over same-cycle writes
        st_d.wdt_rst = 1'b0;
        if (expire) begin
            st_d.flags[0] = 1'b1;
            if (st_q.mode.wdt) begin
                st_d.wdt_rst  = 1'b1;
                st_d.mode.run = 1'b0;
            end else if (!st_q.mode.cont) begin
                st_d.mode.run = 1'b0;
            end else begin
                st_d.act_pre = st_d.count[CNT_W-1:PER_W];
                st_d.act_per = st_d.count[PER_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_MODE: begin
                bus_rdata[BIT_WDT]  = st_q.mode.wdt;
                bus_rdata[BIT_RUN]  = st_q.mode.run;
                bus_rdata[BIT_CONT] = st_q.mode.cont;
                bus_rdata[BIT_IRQ]  = st_q.mode.irq;
            end
            REG_COUNT: bus_rdata = st_q.count;
            REG_STAT:  bus_rdata[FLAG_W-1:0] = st_q.flags;
            default:   bus_rdata = '0;
        endcase
    end

    assign run       = st_q.mode.run;
    assign act_pre   = st_q.act_pre;
    assign act_per   = st_q.act_per;
    assign event_o   = (|st_q.flags) && st_q.mode.irq;
    assign wdt_rst_o = st_q.wdt_rst;

    AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st_q.flags[0]) else $error("flag not set"); // R2
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !st_q.mode.cont) |=> !st_q.mode.run) else $error("one-shot kept running"); // R5
    AST_WDT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && st_q.mode.wdt) |=> (st_q.wdt_rst && !st_q.mode.run)) else $error("watchdog expiry"); // R10
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wdt_rst |=> !st_q.wdt_rst) else $error("reset pulse too long"); // R10
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && mode_byte && (nm.wdt || nm.run)) |=> st_q.mode.wdt) else $error("lock broken"); // R11
endmodule

// File: rtl/interval_wdt_timer.sv
module interval_wdt_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NBYTES-1:0] bus_wstrb,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tmr_event,
    output logic              wdt_reset
);
    logic             restart, run, tick, expire;
    logic [PRE_W-1:0] act_pre;
    logic [PER_W-1:0] act_per;

    tmr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .expire    (expire),
        .bus_rdata (bus_rdata),
        .restart   (restart),
        .run       (run),
        .act_pre   (act_pre),
        .act_per   (act_per),
        .event_o   (tmr_event),
        .wdt_rst_o (wdt_reset)
    );

    tmr_stage #(.W(PRE_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .limit   (act_pre),
        .wrap_o  (tick)
    );

    tmr_stage #(.W(PER_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tick),
        .restart (restart),
        .limit   (act_per),
        .wrap_o  (expire)
    );
endmodule

// File: tb/interval_wdt_timer_test.sv
module interval_wdt_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;
    logic        tmr_event, wdt_reset;

    int total = 0;
    int bad = 0;

    localparam logic [31:0] M_IRQ  = 32'h0000_0100;
    localparam logic [31:0] M_CONT = 32'h0000_0400;
    localparam logic [31:0] M_RUN  = 32'h0000_1000;
    localparam logic [31:0] M_WDT  = 32'h0000_8000;

    interval_wdt_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
        .tmr_event(tmr_event), .wdt_reset(wdt_reset)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(2'd0, v); chk("R1 mode", v, 0);
        rd(2'd1, v); chk("R1 count", v, 0);
        rd(2'd2, v); chk("R1 status", v, 0);
        chk("R1 event", {31'b0, tmr_event}, 0);
        chk("R1 wdt_reset", {31'b0, wdt_reset}, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        do_reset();
        wr(2'd1, {16'd3, 16'd4}, 4'hF);
        wr(2'd0, M_RUN | M_IRQ, 4'hF);
        idle(11);
        rd(2'd2, v); chk("R2 no flag before 12", v, 0);
        chk("R7 event low", {31'b0, tmr_event}, 0);
        idle(1);
        rd(2'd2, v); chk("R2 flag at 12", v, 1);
        chk("R7 event high", {31'b0, tmr_event}, 1);
        rd(2'd0, v); chk("R5 run cleared", v, M_IRQ);
        idle(30);
        rd(2'd2, v); chk("R5 single expiry", v, 1);
        wr(2'd2, 32'h0, 4'hF);
        rd(2'd2, v); chk("R7 zero write keeps flag", v, 1);
        wr(2'd2, 32'h1, 4'hF);
        rd(2'd2, v); chk("R7 w1c", v, 0);
        chk("R7 event after clear", {31'b0, tmr_event}, 0);
    endtask

    task automatic t_cont();
        logic [31:0] v;
        do_reset();
        wr(2'd1, {16'd2, 16'd5}, 4'hF);
        wr(2'd0, M_RUN | M_CONT | M_IRQ, 4'hF);
        idle(9);
        rd(2'd2, v); chk("R6 no flag at 9", v, 0);
        idle(1);
        rd(2'd2, v); chk("R6 flag at 10", v, 1);
        wr(2'd2, 32'h1, 4'h1);
        wr(2'd1, {16'd1, 16'd4}, 4'hF);
        rd(2'd1, v); chk("R12 count stored", v, {16'd1, 16'd4});
        idle(7);
        rd(2'd2, v); chk("R12 old length kept", v, 0);
        idle(1);
        rd(2'd2, v); chk("R6 second expiry at 20", v, 1);
        rd(2'd0, v); chk("R6 run stays", v, M_RUN | M_CONT | M_IRQ);
        wr(2'd2, 32'h1, 4'h1);
        idle(2);
        rd(2'd2, v); chk("R12 new length not early", v, 0);
        idle(1);
        rd(2'd2, v); chk("R12 new length used", v, 1);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        do_reset();
        wr(2'd1, {16'd1, 16'd6}, 4'hF);
        wr(2'd0, M_RUN | M_IRQ, 4'hF);
        idle(3);
        wr(2'd0, M_IRQ, 4'hF);
        idle(20);
        rd(2'd2, v); chk("R4 halted", v, 0);
        wr(2'd0, M_RUN | M_IRQ, 4'hF);
        idle(5);
        rd(2'd2, v); chk("R4 full restart", v, 0);
        idle(1);
        rd(2'd2, v); chk("R4 expiry after restart", v, 1);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        do_reset();
        wr(2'd1, {16'd0, 16'd1}, 4'hF);
        wr(2'd0, M_RUN, 4'hF);
        idle(65535);
        rd(2'd2, v); chk("R3 prescale 0 not early", v, 0);
        idle(1);
        rd(2'd2, v); chk("R3 prescale 0 = 65536", v, 1);
        do_reset();
        wr(2'd1, {16'd1, 16'd0}, 4'hF);
        wr(2'd0, M_RUN, 4'hF);
        idle(65535);
        rd(2'd2, v); chk("R3 period 0 not early", v, 0);
        idle(1);
        rd(2'd2, v); chk("R3 period 0 = 65536", v, 1);
    endtask

    task automatic t_wdt();
        logic [31:0] v;
        do_reset();
        wr(2'd1, {16'd2, 16'd5}, 4'hF);
        wr(2'd0, M_WDT | M_RUN | M_IRQ, 4'hF);
        rd(2'd0, v); chk("R8 irq forced off", v, M_WDT | M_RUN);
        wr(2'd0, 32'h5A00_0000, 4'h8);
        wr(2'd0, M_RUN | M_IRQ, 4'hF);
        rd(2'd0, v); chk("R11 locked write ignored", v, M_WDT | M_RUN);
        idle(7);
        chk("R9 wrong key no restart (no early pulse)", {31'b0, wdt_reset}, 0);
        idle(1);
        chk("R10 pulse at expiry", {31'b0, wdt_reset}, 1);
        chk("R8 event masked", {31'b0, tmr_event}, 0);
        rd(2'd0, v); chk("R10 run cleared", v, M_WDT);
        idle(1);
        chk("R10 pulse one cycle", {31'b0, wdt_reset}, 0);
        wr(2'd2, 32'hF, 4'h1);
        wr(2'd0, M_WDT | M_RUN, 4'hF);
        idle(7);
        wr(2'd0, 32'hA500_0000, 4'h8);
        idle(9);
        chk("R9 kick delays expiry", {31'b0, wdt_reset}, 0);
        idle(1);
        chk("R9 expiry after kick", {31'b0, wdt_reset}, 1);
        idle(2);
        wr(2'd0, M_WDT | M_RUN, 4'hF);
        idle(3);
        wr(2'd0, 32'h0, 4'hF);
        rd(2'd0, v); chk("R11 release accepted", v, 0);
        idle(30);
        chk("R11 no pulse after release", {31'b0, wdt_reset}, 0);
    endtask

    initial begin
        idle(1);
        t_reset();
        t_oneshot();
        t_cont();
        t_halt();
        t_wdt();
        t_zero();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule